// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the system clock into time quanta and arranges them into CAN bit periods. Each bit starts with a one-quantum synchronisation segment, continues with a programmable first phase that ends at the sample point, and closes with a programmable second phase. The block emits a one-clock tick per quantum, a one-clock strobe when a new bit begins and a one-clock strobe at the sample point. It also latches the received level there as the sampled bit.

The timing setting arrives on four configuration inputs: prescaler, phase 1, phase 2 and jump width. Each input carries its length minus one. A recessive-to-dominant transition on the already synchronised receive line realigns the bit timing. When hard synchronisation is enabled, that transition restarts the bit at the synchronisation segment. Otherwise it resynchronises the bit, lengthening phase 1 or shortening phase 2 by no more than the jump width, and only once per bit. Frame decoding, stuffing and arbitration belong to the controller that uses these strobes.

Top module: `can_bit_timer`

## Requirements
- R1: With prescaler field P the quantum tick is high for one clock in every P+1 clocks.
- R2: Without edges on the receive line a bit lasts 1 + (T1+1) + (T2+1) quanta, where T1 and T2 are the phase fields, and the bit-start strobe is high for one clock per bit.
- R3: The sample strobe is high for one clock and follows the bit-start strobe by (T1+2)·(P+1) clocks when no resynchronisation occurs.
- R4: The sampled bit takes the receive level on the quantum tick that ends phase 1, and holds it until the next sample strobe. Its reset value is 1 (recessive).
- R5: With hard synchronisation enabled, a falling edge of the receive line (1 then 0 on consecutive clocks) restarts the bit. The bit-start strobe follows on the next clock, the prescaler restarts, and the nominal sample and bit timing of R2 and R3 apply from there.
- R6: Rising edges of the receive line neither restart nor resynchronise the bit.
- R7: With hard synchronisation disabled, a falling edge seen in quantum k of phase 1 (k = 1 for its first quantum) lengthens phase 1 by min(k, J+1) quanta, where J is the jump-width field.
- R8: With hard synchronisation disabled, a falling edge seen in phase 2 shortens phase 2 by min(r, J+1) quanta. Here r is the number of phase-2 quanta that follow the quantum holding the edge.
- R9: At most one resynchronisation takes effect per bit, and a falling edge in the synchronisation quantum causes none.
- R10: A legal setting has phase 1 of at least two quanta (T1 ≥ 1) and phase 2 of at least the jump width (T2 ≥ J).
- R11: During and straight after reset the sample and bit-start strobes are low and the sampled bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Synchronised receive line, 0 is dominant |
| hard_sync_en_i | input | 1 | Falling edges restart the bit instead of resynchronising it |
| brp_m1_i | input | PRESC_W | Prescaler, clocks per quantum minus one |
| tseg1_m1_i | input | SEG1_W | Phase 1 length in quanta minus one |
| tseg2_m1_i | input | SEG2_W | Phase 2 length in quanta minus one |
| sjw_m1_i | input | SJW_W | Jump width in quanta minus one |
| tq_tick_o | output | 1 | One-clock tick at the end of each quantum |
| sample_o | output | 1 | One-clock strobe at the sample point |
| bit_o | output | 1 | Sampled bit value |
| bit_start_o | output | 1 | One-clock strobe at the start of each bit |

## Verification
The bench places single-clock dominant pulses in chosen quanta. It hits the synchronisation quantum, the first and last quantum of phase 1, and each quantum of phase 2. A design that clips to the phase error but not to the jump width, or the reverse, lands the sample or bit-start strobe a quantum off. A second edge within one bit catches a design that resynchronises twice. A mid-bit hard restart with the line held low checks that the prescaler restarts and that the sampled bit follows the line. A rising edge with hard synchronisation enabled checks for spurious restarts. Four settings, including a one-clock quantum and minimum phases, catch off-by-one decoding of the minus-one fields.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   typedef enum logic [1:0] {
      PH_SYNC = 2'd0,
      PH_SEG1 = 2'd1,
      PH_SEG2 = 2'd2
   } bt_phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
   parameter int unsigned PRESC_W = 6
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               restart_i,
   input  logic [PRESC_W-1:0] brp_m1_i,
   output logic               tick_o
);

   logic [PRESC_W-1:0] cnt_q;

   assign tick_o = (cnt_q == brp_m1_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_i,
   output logic fall_o
);

   logic rx_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) rx_q <= 1'b1;
      else         rx_q <= rx_i;
   end

   assign fall_o = rx_q & ~rx_i;

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
   import can_bt_pkg::*;
#(
   parameter int unsigned SEG1_W = 4,
   parameter int unsigned SEG2_W = 3,
   parameter int unsigned SJW_W  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              fall_i,
   input  logic              hard_en_i,
   input  logic              rx_i,
   input  logic [SEG1_W-1:0] tseg1_m1_i,
   input  logic [SEG2_W-1:0] tseg2_m1_i,
   input  logic [SJW_W-1:0]  sjw_m1_i,
   output logic              restart_o,
   output logic              sample_o,
   output logic              bit_o,
   output logic              bit_start_o
);

   localparam int unsigned CNT_W = max2(SEG1_W, SEG2_W) + 1;

   bt_phase_e        phase_q;
   logic [CNT_W-1:0] qcnt_q, ext_q, cut_q;
   logic             resynced_q;

   logic [CNT_W-1:0] t1, t2, sjw_len, err1, err2, adj1, adj2, ext_now, cut_now;
   logic             hard, rs_ok, rs1, rs2, seg1_last, seg2_last;

   assign t1      = {{(CNT_W-SEG1_W){1'b0}}, tseg1_m1_i};
   assign t2      = {{(CNT_W-SEG2_W){1'b0}}, tseg2_m1_i};
   assign sjw_len = {{(CNT_W-SJW_W){1'b0}}, sjw_m1_i} + 1'b1;

   assign err1 = qcnt_q + 1'b1;
   assign err2 = t2 - qcnt_q;
   assign adj1 = (err1 < sjw_len) ? err1 : sjw_len;
   assign adj2 = (err2 < sjw_len) ? err2 : sjw_len;

   assign hard  = hard_en_i && fall_i;
   assign rs_ok = !hard_en_i && fall_i && !resynced_q;
   assign rs1   = rs_ok && (phase_q == PH_SEG1);
   assign rs2   = rs_ok && (phase_q == PH_SEG2);

   assign ext_now   = rs1 ? adj1 : ext_q;
   assign cut_now   = rs2 ? adj2 : cut_q;
   assign seg1_last = (qcnt_q == t1 + ext_now);
   assign seg2_last = (qcnt_q == t2 - cut_now);

   assign restart_o = hard;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q     <= PH_SYNC;
         qcnt_q      <= '0;
         ext_q       <= '0;
         cut_q       <= '0;
         resynced_q  <= 1'b0;
         sample_o    <= 1'b0;
         bit_o       <= 1'b1;
         bit_start_o <= 1'b0;
      end else begin
         sample_o    <= 1'b0;
         bit_start_o <= 1'b0;
         if (hard) begin
            phase_q     <= PH_SYNC;
            qcnt_q      <= '0;
            ext_q       <= '0;
            cut_q       <= '0;
            resynced_q  <= 1'b0;
            bit_start_o <= 1'b1;
         end else begin
            if (rs1) begin
               ext_q      <= adj1;
               resynced_q <= 1'b1;
            end
            if (rs2) begin
               cut_q      <= adj2;
               resynced_q <= 1'b1;
            end
            if (tick_i) begin
               unique case (phase_q)
                  PH_SYNC: begin
                     phase_q <= PH_SEG1;
                     qcnt_q  <= '0;
                  end
                  PH_SEG1: begin
                     if (seg1_last) begin
                        phase_q  <= PH_SEG2;
                        qcnt_q   <= '0;
                        sample_o <= 1'b1;
                        bit_o    <= rx_i;
                     end else begin
                        qcnt_q <= qcnt_q + 1'b1;
                     end
                  end
                  PH_SEG2: begin
                     if (seg2_last) begin
                        phase_q     <= PH_SYNC;
                        qcnt_q      <= '0;
                        ext_q       <= '0;
                        cut_q       <= '0;
                        resynced_q  <= 1'b0;
                        bit_start_o <= 1'b1;
                     end else begin
                        qcnt_q <= qcnt_q + 1'b1;
                     end
                  end
                  default: begin
                     phase_q <= PH_SYNC;
                     qcnt_q  <= '0;
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int unsigned PRESC_W = 6,
   parameter int unsigned SEG1_W  = 4,
   parameter int unsigned SEG2_W  = 3,
   parameter int unsigned SJW_W   = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rx_i,
   input  logic               hard_sync_en_i,
   input  logic [PRESC_W-1:0] brp_m1_i,
   input  logic [SEG1_W-1:0]  tseg1_m1_i,
   input  logic [SEG2_W-1:0]  tseg2_m1_i,
   input  logic [SJW_W-1:0]   sjw_m1_i,
   output logic               tq_tick_o,
   output logic               sample_o,
   output logic               bit_o,
   output logic               bit_start_o
);

   generate
      if (PRESC_W < 1 || SEG1_W < 2 || SEG2_W < 1) begin : g_bad_width
         $error("can_bit_timer: field widths too small");
      end
      if (SJW_W > SEG2_W || SJW_W > SEG1_W) begin : g_bad_sjw
         $error("can_bit_timer: jump width field wider than a phase field");
      end
   endgenerate

   logic fall, restart;

   can_bt_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rx_i   (rx_i),
      .fall_o (fall)
   );

   can_bt_presc #(.PRESC_W(PRESC_W)) u_presc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .brp_m1_i  (brp_m1_i),
      .tick_o    (tq_tick_o)
   );

   can_bt_seq #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tq_tick_o),
      .fall_i      (fall),
      .hard_en_i   (hard_sync_en_i),
      .rx_i        (rx_i),
      .tseg1_m1_i  (tseg1_m1_i),
      .tseg2_m1_i  (tseg2_m1_i),
      .sjw_m1_i    (sjw_m1_i),
      .restart_o   (restart),
      .sample_o    (sample_o),
      .bit_o       (bit_o),
      .bit_start_o (bit_start_o)
   );

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
   parameter int unsigned PRESC_W = 6,
   parameter int unsigned SEG1_W  = 4,
   parameter int unsigned SEG2_W  = 3,
   parameter int unsigned SJW_W   = 2
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               rx_i,
   input logic               hard_sync_en_i,
   input logic [PRESC_W-1:0] brp_m1_i,
   input logic [SEG1_W-1:0]  tseg1_m1_i,
   input logic [SEG2_W-1:0]  tseg2_m1_i,
   input logic [SJW_W-1:0]   sjw_m1_i,
   input logic               tq_tick_o,
   input logic               sample_o,
   input logic               bit_o,
   input logic               bit_start_o
);

   logic rx_d;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) rx_d <= 1'b1;
      else         rx_d <= rx_i;
   end

   assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tq_tick_o && brp_m1_i != '0 && !(hard_sync_en_i && rx_d && !rx_i)) |=> !tq_tick_o);

   assert_bit_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bit_start_o && !(hard_sync_en_i && rx_d && !rx_i)) |=> !bit_start_o);

   assert_sample_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_o |=> !sample_o);

   assert_strobes_apart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sample_o && bit_start_o));

   assert_bit_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(bit_o) |-> sample_o);

   assert_hard_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hard_sync_en_i && rx_d && !rx_i) |=> bit_start_o);

   assert_rise_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rx_d && rx_i && !tq_tick_o) |=> !bit_start_o);

   assert_cfg_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tseg1_m1_i != '0) && ({1'b0, tseg2_m1_i} >= {1'b0, sjw_m1_i}));

endmodule

bind can_bit_timer can_bit_timer_chk #(
   .PRESC_W(PRESC_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)
) u_chk (.*);

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       hard_en = 1'b0;
   logic [5:0] brp = 6'd1;
   logic [3:0] t1 = 4'd3;
   logic [2:0] t2 = 3'd2;
   logic [1:0] sjw = 2'd1;
   logic       tq_tick, sample, bitv, bit_start;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   can_bit_timer u0 (
      .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .hard_sync_en_i(hard_en),
      .brp_m1_i(brp), .tseg1_m1_i(t1), .tseg2_m1_i(t2), .sjw_m1_i(sjw),
      .tq_tick_o(tq_tick), .sample_o(sample), .bit_o(bitv), .bit_start_o(bit_start)
   );

   // per row: prescaler, phase1, phase2, jump width | tick period, sample offset, bit period
   localparam int NV = 4;
   localparam int VEC [NV][7] = '{
      '{1, 3,  2, 1, 2, 10, 16},
      '{0, 12, 1, 0, 1, 14, 16},
      '{2, 1,  0, 0, 3, 9,  12},
      '{5, 7,  3, 3, 6, 54, 78}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_bs();
      do @(negedge clk); while (!bit_start);
   endtask

   // from a bit start, measure clocks to sample and to next bit start
   task automatic measure(output int samp_c, output int per_c, output logic sbit);
      int c = 0;
      samp_c = -1;
      sbit = 1'b1;
      wait_bs();
      do begin
         @(negedge clk);
         c++;
         if (sample) begin samp_c = c; sbit = bitv; end
      end while (!bit_start);
      per_c = c;
   endtask

   // dominant one-clock pulses at offsets d1 and d2 (d2 < 0: none) after a bit start
   task automatic resync_case(input int d1, input int d2, input int exp_s, input int exp_p,
                              input string req);
      int c = 0;
      int s = -1;
      wait_bs();
      if (d1 == 0) rx = 1'b0;
      do begin
         @(negedge clk);
         c++;
         if (sample) s = c;
         rx = !(c == d1 || c == d2);
      end while (!bit_start);
      rx = 1'b1;
      check(s == exp_s, {req, " sample offset"}, s, exp_s);
      check(c == exp_p, {req, " bit period"}, c, exp_p);
   endtask

   initial begin
      int sc, pc, tc;
      logic sb;
      // R11: reset state
      repeat (2) @(negedge clk);
      check(sample == 1'b0, "R11 sample in reset", int'(sample), 0);
      check(bit_start == 1'b0, "R11 bit_start in reset", int'(bit_start), 0);
      check(bitv == 1'b1, "R11 bit in reset", int'(bitv), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(sample == 1'b0 && bit_start == 1'b0 && bitv == 1'b1, "R11 after reset",
            int'({sample, bit_start, bitv}), 1);

      // table walk: R1, R2, R3, R10 settings
      for (int i = 0; i < NV; i++) begin
         brp = 6'(VEC[i][0]); t1 = 4'(VEC[i][1]); t2 = 3'(VEC[i][2]); sjw = 2'(VEC[i][3]);
         do_reset();
         do @(negedge clk); while (!tq_tick);
         tc = 0;
         do begin @(negedge clk); tc++; end while (!tq_tick);
         check(tc == VEC[i][4], $sformatf("R1 tick period row %0d", i), tc, VEC[i][4]);
         measure(sc, pc, sb);
         check(sc == VEC[i][5], $sformatf("R3 sample offset row %0d", i), sc, VEC[i][5]);
         check(pc == VEC[i][6], $sformatf("R2 bit period row %0d", i), pc, VEC[i][6]);
         check(sb == 1'b1, $sformatf("R4 idle bit row %0d", i), int'(sb), 1);
      end

      // directed tests on row 0 setting: quantum 2 clocks, phase1 4, phase2 3, jump 2
      brp = 6'd1; t1 = 4'd3; t2 = 3'd2; sjw = 2'd1;
      do_reset();

      // R5 hard restart mid-bit, line held low through sample (R4)
      hard_en = 1'b1;
      wait_bs();
      repeat (5) @(negedge clk);
      rx = 1'b0;
      @(negedge clk);
      check(bit_start == 1'b1, "R5 bit start after edge", int'(bit_start), 1);
      begin
         int c = 0;
         int s = -1;
         do begin
            @(negedge clk);
            c++;
            if (sample) begin
               s = c;
               check(bitv == 1'b0, "R4 sampled dominant", int'(bitv), 0);
               rx = 1'b1; // R6: rising edge with hard sync enabled
            end
         end while (!bit_start);
         check(s == 10, "R5 sample after restart", s, 10);
         check(c == 16, "R6 bit period after rising edge", c, 16);
      end
      hard_en = 1'b0;

      // R9: edge in synchronisation quantum
      resync_case(0, -1, 10, 16, "R9 sync quantum edge");
      // R7: phase 1 lengthening
      resync_case(2, -1, 12, 18, "R7 phase1 first quantum");
      resync_case(8, -1, 14, 20, "R7 phase1 last quantum clipped");
      // R9: second edge in same bit ignored
      resync_case(2, 6, 12, 18, "R9 second edge ignored");
      // R8: phase 2 shortening
      resync_case(10, -1, 10, 12, "R8 phase2 first quantum");
      resync_case(12, -1, 10, 14, "R8 phase2 middle quantum");
      resync_case(14, -1, 10, 16, "R8 phase2 last quantum");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

endmodule